// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a small bank of general-purpose registers. It serves two reads and one write in every clock cycle, with all activity on the rising edge. Each of the three ports picks a register with its own address. Read results are registered, so the data for an address presented before an edge appears on the port output just after that edge.

Entry 0 is a constant zero. A read of address 0 on either port returns zero. A write aimed at address 0 is dropped. There is no forwarding path: a read that meets a write to the same entry in the same cycle returns the value held before that write. An active-high asynchronous reset clears every entry and both read output registers.

Top module: `dual_read_regfile`

## Requirements
- R1: While `rst` is high, and after it falls, both read outputs are zero and every entry reads as zero until it is written.
- R2: For each read port, the address applied before a rising edge selects the entry whose value, as held before that edge, drives the port output from just after that edge until the next one.
- R3: When `wp_en` is 1 and `wp_addr` is nonzero at a rising edge, `wp_data` is stored into entry `wp_addr` at that edge.
- R4: When `wp_en` is 0 at a rising edge, no entry changes, whatever `wp_addr` and `wp_data` hold.
- R5: A read of address 0 on either port returns zero, including in a cycle where a write to address 0 is requested.
- R6: A write with `wp_en` = 1 and `wp_addr` = 0 changes no entry.
- R7: A read and a write to the same nonzero entry in one cycle return the old contents on the read port. The new contents are visible from the following read onwards.
- R8: When both read ports present the same address, they return identical data.
- R9: Two reads of different entries and one write to a third entry can all take place in one cycle, each with the results given above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all storage |
| rst | input | 1 | Asynchronous active-high reset |
| wp_en | input | 1 | Write enable |
| wp_addr | input | 3 | Write entry select |
| wp_data | input | 16 | Data to store |
| rp0_addr | input | 3 | Read port 0 entry select |
| rp0_data | output | 16 | Read port 0 registered result |
| rp1_addr | input | 3 | Read port 1 entry select |
| rp1_data | output | 16 | Read port 1 registered result |

## Verification
A write and a read can both act on the same entry in one cycle. The bench provokes this by writing entry 5 while both read ports select entry 5. It also provokes it by requesting a write to entry 0 while a port reads entry 0. The scoreboard takes its expected read values from its own copy of the entries before it applies that cycle's write. So any forwarding of fresh data, or any leak into entry 0, shows up as a mismatch on the following sample. A long stretch of random traffic then crosses both functions many times more.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int RF_DATA_W_DEF   = 16;
   localparam int RF_NUM_REGS_DEF = 8;

   function automatic bit rf_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rf_wdec.sv
module rf_wdec #(
   parameter int NUM_REGS = rf_pkg::RF_NUM_REGS_DEF,
   parameter bit ZERO_REG = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                en,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      if (ZERO_REG && i == 0) begin : g_tied
         assign sel[i] = 1'b0;
      end else begin : g_live
         assign sel[i] = en && (addr == ADDR_W'(i));
      end
   end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int DATA_W   = rf_pkg::RF_DATA_W_DEF,
   parameter int NUM_REGS = rf_pkg::RF_NUM_REGS_DEF,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REGS-1:0]              sel,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      if (ZERO_REG && i == 0) begin : g_const
         assign regs_q[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst)         q <= '0;
            else if (sel[i]) q <= wdata;
         end
         assign regs_q[i] = q;
      end
   end
endmodule

// File: rtl/rf_rport.sv
module rf_rport #(
   parameter int DATA_W   = rf_pkg::RF_DATA_W_DEF,
   parameter int NUM_REGS = rf_pkg::RF_NUM_REGS_DEF,
   parameter bit ZERO_REG = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
   input  logic [ADDR_W-1:0]                addr,
   output logic [DATA_W-1:0]                data
);
   logic [DATA_W-1:0] pick;

   if (ZERO_REG) begin : g_zmask
      always_comb pick = (addr == '0) ? '0 : regs_q[addr];
   end else begin : g_plain
      always_comb pick = regs_q[addr];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) data <= '0;
      else     data <= pick;
   end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
   parameter int DATA_W   = rf_pkg::RF_DATA_W_DEF,
   parameter int NUM_REGS = rf_pkg::RF_NUM_REGS_DEF,
   parameter bit ZERO_REG = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wp_en,
   input  logic [ADDR_W-1:0] wp_addr,
   input  logic [DATA_W-1:0] wp_data,
   input  logic [ADDR_W-1:0] rp0_addr,
   output logic [DATA_W-1:0] rp0_data,
   input  logic [ADDR_W-1:0] rp1_addr,
   output logic [DATA_W-1:0] rp1_data
);
   localparam int NUM_RP = 2;

   if (!rf_pkg::rf_is_pow2(NUM_REGS)) begin : g_bad_depth
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]             wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [NUM_RP-1:0][ADDR_W-1:0]   rd_addr;
   logic [NUM_RP-1:0][DATA_W-1:0]   rd_data;

   assign rd_addr[0] = rp0_addr;
   assign rd_addr[1] = rp1_addr;
   assign rp0_data   = rd_data[0];
   assign rp1_data   = rd_data[1];

   rf_wdec #(.NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)) u_wdec (
      .en   (wp_en),
      .addr (wp_addr),
      .sel  (wr_sel)
   );

   rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)) u_store (
      .clk    (clk),
      .rst    (rst),
      .sel    (wr_sel),
      .wdata  (wp_data),
      .regs_q (regs_q)
   );

   for (genvar p = 0; p < NUM_RP; p++) begin : g_rp
      rf_rport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)) u_rp (
         .clk    (clk),
         .rst    (rst),
         .regs_q (regs_q),
         .addr   (rd_addr[p]),
         .data   (rd_data[p])
      );
   end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input logic                             clk,
   input logic                             rst,
   input logic                             wp_en,
   input logic [ADDR_W-1:0]                wp_addr,
   input logic [DATA_W-1:0]                wp_data,
   input logic [ADDR_W-1:0]                rp0_addr,
   input logic [DATA_W-1:0]                rp0_data,
   input logic [ADDR_W-1:0]                rp1_addr,
   input logic [DATA_W-1:0]                rp1_data,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
   logic past_ok;
   always_ff @(posedge clk or posedge rst) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   // R1
   always @(posedge clk) begin
      if (rst) begin
         rst_clear_chk: assert (rp0_data == '0 && rp1_data == '0 && regs_q == '0);
      end
   end

   // R2
   rd0_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rp0_addr) != '0) |-> rp0_data == $past(regs_q[rp0_addr]));

   // R2
   rd1_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rp1_addr) != '0) |-> rp1_data == $past(regs_q[rp1_addr]));

   // R3
   wr_store_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(wp_en) && $past(wp_addr) != '0) |-> regs_q[$past(wp_addr)] == $past(wp_data));

   // R4
   wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(wp_en)) |-> $stable(regs_q));

   // R5
   zero_read0_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rp0_addr) == '0) |-> rp0_data == '0);

   // R5
   zero_read1_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rp1_addr) == '0) |-> rp1_data == '0);

   // R6
   zero_write_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(wp_en) && $past(wp_addr) == '0) |-> $stable(regs_q));

   // R8
   same_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rp0_addr) == $past(rp1_addr)) |-> rp0_data == rp1_data);
endmodule

bind dual_read_regfile rf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wp_en    (wp_en),
   .wp_addr  (wp_addr),
   .wp_data  (wp_data),
   .rp0_addr (rp0_addr),
   .rp0_data (rp0_data),
   .rp1_addr (rp1_addr),
   .rp1_data (rp1_data),
   .regs_q   (regs_q)
);

// File: tb/sim_dual_read_regfile.sv
module sim_dual_read_regfile;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wp_en = 1'b0;
   logic [2:0]  wp_addr = '0;
   logic [15:0] wp_data = '0;
   logic [2:0]  rp0_addr = '0;
   logic [2:0]  rp1_addr = '0;
   logic [15:0] rp0_data;
   logic [15:0] rp1_data;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] model [8];
   logic [15:0] q0 [$];
   logic [15:0] q1 [$];
   string       qt [$];

   always #(CLK_P/2) clk = ~clk;

   dual_read_regfile u0 (
      .clk(clk), .rst(rst), .wp_en(wp_en), .wp_addr(wp_addr), .wp_data(wp_data),
      .rp0_addr(rp0_addr), .rp0_data(rp0_data), .rp1_addr(rp1_addr), .rp1_data(rp1_data)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected reads pushed into the scoreboard
   task automatic drive(input bit we, input logic [2:0] wa, input logic [15:0] wd,
                        input logic [2:0] ra0, input logic [2:0] ra1, input string tag);
      @(negedge clk);
      wp_en = we; wp_addr = wa; wp_data = wd; rp0_addr = ra0; rp1_addr = ra1;
      q0.push_back(ra0 == 3'd0 ? 16'h0 : model[ra0]);
      q1.push_back(ra1 == 3'd0 ? 16'h0 : model[ra1]);
      qt.push_back(tag);
      if (we && wa != 3'd0) model[wa] = wd;
   endtask

   task automatic idle_drive();
      @(negedge clk);
      wp_en = 1'b0;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (qt.size() > 0) begin
            string t;
            logic [15:0] e0, e1;
            t = qt.pop_front(); e0 = q0.pop_front(); e1 = q1.pop_front();
            check({t, " port0"}, rp0_data, e0);
            check({t, " port1"}, rp1_data, e1);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 16'h0;
      // R1: outputs zero while reset is held
      rp0_addr = 3'd3; rp1_addr = 3'd5;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      check("R1 reset port0", rp0_data, 16'h0);
      check("R1 reset port1", rp1_data, 16'h0);
      @(negedge clk);
      rst = 1'b0;

      // R1: every entry reads zero after reset
      for (int a = 0; a < 8; a++) drive(1'b0, 3'd0, 16'h0, 3'(a), 3'(7 - a), "R1 post-reset");

      // R3 / R9: fill entries while reading others
      for (int a = 1; a < 8; a++)
         drive(1'b1, 3'(a), 16'hA100 + 16'(a * 16'h0111), 3'(a - 1), 3'((a + 3) % 8), "R3 R9 fill");
      for (int a = 0; a < 8; a++) drive(1'b0, 3'd0, 16'h0, 3'(a), 3'((a + 1) % 8), "R2 R3 readback");

      // R4: enable low ignores address and data
      drive(1'b0, 3'd3, 16'hDEAD, 3'd1, 3'd2, "R4 disabled write");
      drive(1'b0, 3'd0, 16'h0, 3'd3, 3'd3, "R4 entry unchanged");

      // R6 / R5: write to entry 0 is discarded, read of 0 gives zero
      drive(1'b1, 3'd0, 16'hFFFF, 3'd0, 3'd4, "R5 R6 zero write");
      for (int a = 0; a < 8; a++) drive(1'b0, 3'd0, 16'h0, 3'(a), 3'd0, "R6 no change");

      // R7: read during write to same entry returns old value
      drive(1'b1, 3'd5, 16'h5A5A, 3'd5, 3'd5, "R7 same-cycle old");
      drive(1'b0, 3'd0, 16'h0, 3'd5, 3'd6, "R7 next-cycle new");

      // R8: both ports on one entry
      drive(1'b1, 3'd2, 16'h1234, 3'd6, 3'd6, "R8 twin read");
      drive(1'b0, 3'd0, 16'h0, 3'd2, 3'd2, "R8 twin read new");

      // R9: random traffic
      for (int k = 0; k < 400; k++)
         drive(1'($urandom), 3'($urandom), 16'($urandom), 3'($urandom), 3'($urandom), "R9 random");

      idle_drive();
      while (qt.size() > 0) @(negedge clk);
      finish_run();
   end
endmodule